// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block runs one four-beat burst read against a two-bank synchronous DRAM with a 64-bit data bus. A host offers a byte address with a request/acknowledge handshake. The block then drives the command pins (chip select, row strobe, column strobe and write enable, all active low) and the multiplexed address pins cycle by cycle, captures the four returning data beats, and hands them back to the host as one 256-bit word with a single-cycle valid strobe.

Every burst follows the same sequence. It opens a row with an activate command and waits a configurable number of NOP cycles. It then issues a read that closes the row by itself (auto-precharge) and spends four data cycles sampling the bus. A configurable number of quiet cycles follows, so the device can finish its internal precharge before the sequencer returns to idle. Both timing settings are sampled when a request is accepted. The address and the settings may change freely while a burst is running.

Top module: `sdram_burst_rd`

## Requirements
- R1: While reset is held and in the first cycle after it, the pins carry NOP, `sdAddr` is 0, and `reqAck` and `rdValid` are low.
- R2: `reqAck` is high in a cycle only when the block is idle and `reqValid` is high. The request is taken at the next clock edge, and the activate command appears in the cycle that follows. `reqAck` stays low for the whole of a burst, even when `reqValid` is held high.
- R3: Commands are coded on {`sdCsN`,`sdRasN`,`sdCasN`,`sdWeN`} as activate = 0011, read = 0101, NOP = 0111. In every cycle that carries neither activate nor read, the pins carry NOP and `sdAddr` is 0.
- R4: The read command appears exactly `cfgRcd`+1 cycles after the activate command, with `cfgRcd` NOP cycles in between.
- R5: In the activate cycle, `sdAddr[11:0]` equals byte-address bits 22..11, so address bit 22 selects the bank on pin 11.
- R6: In the read cycle, `sdAddr` equals {addr[22], 1, 0, 0, addr[10:3]}: bank on pin 11, auto-precharge flag high on pin 10, pins 9..8 low, and the column on pins 7..0. Address bits 2..0 do not reach the pins.
- R7: `sdDq` is sampled at the clock edges that end the four cycles right after the read cycle. Beat i lands in `rdData[64*i+63:64*i]`. `rdValid` is high for exactly one cycle, the one after the fourth data cycle, and `rdData` keeps its value until the next burst captures.
- R8: After the fourth data cycle the block waits `cfgTpc` cycles with NOP on the pins and then goes idle. With `cfgTpc` = 0 it is idle in the cycle right after the fourth data cycle.
- R9: Changes to `reqAddr`, `cfgRcd` and `cfgTpc` after the request has been accepted have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SDRAM command clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgRcd | input | 2 | Number of NOP cycles between activate and read |
| cfgTpc | input | 3 | Number of quiet cycles after the last data cycle |
| reqValid | input | 1 | Host read request |
| reqAddr | input | 23 | Byte address of the burst |
| reqAck | output | 1 | Request accepted at the next edge |
| rdValid | output | 1 | One-cycle strobe: `rdData` holds a fresh burst |
| rdData | output | 256 | Four captured beats, beat 0 in the low 64 bits |
| sdCsN | output | 1 | SDRAM chip select, active low |
| sdRasN | output | 1 | SDRAM row strobe, active low |
| sdCasN | output | 1 | SDRAM column strobe, active low |
| sdWeN | output | 1 | SDRAM write enable, active low |
| sdAddr | output | 12 | Multiplexed SDRAM row/column address |
| sdDq | input | 64 | SDRAM read data bus |

## Verification
The hardest case to reach from the ports is a request arriving while a burst is still in its precharge wait. A new address and new timing settings present in that same window must neither shorten the wait nor leak into the running burst. The stimulus keeps `reqValid` high from the first cycle of a burst, with the next address and settings already on the inputs. This puts back-to-back bursts exactly on the idle boundary, including the case where the wait is zero and the valid strobe shares its cycle with the next acknowledge. A behavioural device model in the bench measures activate-to-read spacing from the pins, and it flags any command other than NOP during the data and wait cycles. It also returns data built from the row and column it saw on the pins, so an address-mux fault shows up as wrong data.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  // {CS#, RAS#, CAS#, WE#}
  typedef enum logic [3:0] {
    CMD_ACT  = 4'b0011,
    CMD_READ = 4'b0101,
    CMD_NOP  = 4'b0111
  } sdCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // request taken this edge
    logic selRow;    // row address on pins
    logic selCol;    // column address on pins
    logic capture;   // data cycle: sample bus at end
    logic lastBeat;  // this data cycle is the final one
  } pathStrb_t;

endpackage

// File: rtl/sdram_rd_ctrl.sv
module sdram_rd_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int RCD_W = 2,
  parameter int TPC_W = 3,
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [RCD_W-1:0] cfgRcd,
  input  logic [TPC_W-1:0] cfgTpc,
  output logic             reqAck,
  output pathStrb_t        strb,
  output sdCmd_e           cmd
);

  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int MAX_AB = (RCD_W > BEAT_W) ? RCD_W : BEAT_W;
  localparam int CNT_W  = (TPC_W > MAX_AB) ? TPC_W : MAX_AB;

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_RWAIT, S_READ, S_DATA, S_PWAIT
  } state_e;

  state_e           st, stN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [RCD_W-1:0] rcdQ;
  logic [TPC_W-1:0] tpcQ;

  always_comb begin
    stN  = st;
    cntN = cnt;
    unique case (st)
      S_IDLE: if (reqValid) stN = S_ACT;
      S_ACT: begin
        cntN = CNT_W'(1);
        stN  = (rcdQ == '0) ? S_READ : S_RWAIT;
      end
      S_RWAIT: begin
        if (cnt == CNT_W'(rcdQ)) stN = S_READ;
        else cntN = cnt + CNT_W'(1);
      end
      S_READ: begin
        cntN = '0;
        stN  = S_DATA;
      end
      S_DATA: begin
        if (cnt == CNT_W'(BEATS - 1)) begin
          cntN = CNT_W'(1);
          stN  = (tpcQ == '0) ? S_IDLE : S_PWAIT;
        end else begin
          cntN = cnt + CNT_W'(1);
        end
      end
      S_PWAIT: begin
        if (cnt == CNT_W'(tpcQ)) stN = S_IDLE;
        else cntN = cnt + CNT_W'(1);
      end
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= S_IDLE;
      cnt  <= '0;
      rcdQ <= '0;
      tpcQ <= '0;
    end else begin
      st  <= stN;
      cnt <= cntN;
      if (st == S_IDLE && reqValid) begin
        rcdQ <= cfgRcd;
        tpcQ <= cfgTpc;
      end
    end
  end

  assign reqAck = (st == S_IDLE) && reqValid;

  always_comb begin
    strb.latchReq = reqAck;
    strb.selRow   = (st == S_ACT);
    strb.selCol   = (st == S_READ);
    strb.capture  = (st == S_DATA);
    strb.lastBeat = (st == S_DATA) && (cnt == CNT_W'(BEATS - 1));
  end

  always_comb begin
    unique case (st)
      S_ACT:   cmd = CMD_ACT;
      S_READ:  cmd = CMD_READ;
      default: cmd = CMD_NOP;
    endcase
  end

  // R7: a read is always followed by a data cycle
  a_r7_read_then_data: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_READ) |=> (st == S_DATA));

  // R4: row wait ends only in the read cycle
  a_r4_wait_to_read: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_RWAIT) |=> (st == S_RWAIT || st == S_READ));

  // R8: precharge wait never exceeds the latched count
  a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_PWAIT) |-> (cnt <= CNT_W'(tpcQ) && cnt != '0));

endmodule

// File: rtl/sdram_rd_path.sv
module sdram_rd_path
  import sdram_rd_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  parameter int SA_W   = 12,
  parameter int COL_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pathStrb_t               strb,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       sdDq,
  output logic [SA_W-1:0]         sdAddr,
  output logic [BEATS*DATA_W-1:0] rdData,
  output logic                    rdValid
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int PAD_W  = SA_W - 2 - COL_W;

  logic [ADDR_W-1:BYTE_W] addrQ;
  logic [BEAT_W-1:0]      beatQ;
  logic [DATA_W-1:0]      beatR [BEATS];
  logic                   unusedLowBits;

  assign unusedLowBits = ^reqAddr[BYTE_W-1:0];

  logic [SA_W-1:0]  rowAddr, colAddr;
  logic [COL_W-1:0] colBits;

  assign rowAddr = addrQ[ADDR_W-1 -: SA_W];
  assign colBits = addrQ[BYTE_W+COL_W-1 : BYTE_W];
  assign colAddr = {addrQ[ADDR_W-1], 1'b1, {PAD_W{1'b0}}, colBits};

  always_comb begin
    if (strb.selRow)      sdAddr = rowAddr;
    else if (strb.selCol) sdAddr = colAddr;
    else                  sdAddr = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      beatQ   <= '0;
      rdValid <= 1'b0;
      for (int i = 0; i < BEATS; i++) beatR[i] <= '0;
    end else begin
      rdValid <= strb.capture && strb.lastBeat;
      if (strb.latchReq) addrQ <= reqAddr[ADDR_W-1:BYTE_W];
      if (strb.selCol) beatQ <= '0;
      else if (strb.capture) beatQ <= beatQ + BEAT_W'(1);
      if (strb.capture) begin
        for (int i = 0; i < BEATS; i++)
          if (beatQ == BEAT_W'(i)) beatR[i] <= sdDq;
      end
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_pack
    assign rdData[g*DATA_W +: DATA_W] = beatR[g];
  end

  // R7: control's last-beat flag agrees with the datapath beat index
  a_r7_last_beat_index: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastBeat |-> (beatQ == BEAT_W'(BEATS - 1)));

  // R7: capture never starts without a preceding column cycle
  a_r7_capture_after_col: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && beatQ == '0) |-> $past(strb.selCol));

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
  import sdram_rd_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  parameter int SA_W   = 12,
  parameter int COL_W  = 8,
  parameter int RCD_W  = 2,
  parameter int TPC_W  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [RCD_W-1:0]        cfgRcd,
  input  logic [TPC_W-1:0]        cfgTpc,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  output logic                    reqAck,
  output logic                    rdValid,
  output logic [BEATS*DATA_W-1:0] rdData,
  output logic                    sdCsN,
  output logic                    sdRasN,
  output logic                    sdCasN,
  output logic                    sdWeN,
  output logic [SA_W-1:0]         sdAddr,
  input  logic [DATA_W-1:0]       sdDq
);

  pathStrb_t strb;
  sdCmd_e    cmd;

  sdram_rd_ctrl #(.RCD_W(RCD_W), .TPC_W(TPC_W), .BEATS(BEATS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .cfgRcd(cfgRcd), .cfgTpc(cfgTpc),
    .reqAck(reqAck), .strb(strb), .cmd(cmd)
  );

  sdram_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS),
                  .SA_W(SA_W), .COL_W(COL_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .sdDq(sdDq),
    .sdAddr(sdAddr), .rdData(rdData), .rdValid(rdValid)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmd;

  // R2: an accepted request is followed by an activate
  a_r2_ack_then_act: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> ({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0011));

  // R5: the activate carries the row of the accepted address
  a_r5_row_addr: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> (sdAddr == $past(reqAddr[ADDR_W-1 -: SA_W])));

  // R6: the read carries the auto-precharge flag and zero padding
  a_r6_col_flags: assert property (@(posedge clk) disable iff (!rstN)
    ({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0101) |-> (sdAddr[SA_W-2] && sdAddr[SA_W-3 -: 2] == 2'b00));

  // R7: valid lasts one cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: tb/tb_sdram_burst_rd.sv
module tb_sdram_burst_rd;

  logic         clk = 1'b0;
  logic         rstN;
  logic [1:0]   cfgRcd;
  logic [2:0]   cfgTpc;
  logic         reqValid;
  logic [22:0]  reqAddr;
  logic         reqAck, rdValid;
  logic [255:0] rdData;
  logic         sdCsN, sdRasN, sdCasN, sdWeN;
  logic [11:0]  sdAddr;
  logic [63:0]  sdDq;

  always #5 clk = ~clk;

  sdram_burst_rd dut (
    .clk(clk), .rstN(rstN), .cfgRcd(cfgRcd), .cfgTpc(cfgTpc),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqAck(reqAck),
    .rdValid(rdValid), .rdData(rdData),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr), .sdDq(sdDq)
  );

  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_NOP = 4'b0111;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] beatVal(input logic [19:0] a, input int i);
    return {12'hC0D, a, 24'h5A5A5A, 6'h0, 2'(i)};
  endfunction

  // behavioural device model
  int          curRcd = 0, curTpc = 0;
  int          sinceAct = 100, dqCnt = 0, guard = 0;
  logic [11:0] rowSeen = '0;
  logic [7:0]  colSeen = '0;

  always @(negedge clk) begin
    logic [3:0] c;
    c = {sdCsN, sdRasN, sdCasN, sdWeN};
    if (dqCnt > 0) begin
      sdDq = beatVal({rowSeen, colSeen}, 4 - dqCnt);
      dqCnt--;
    end else begin
      sdDq = 64'hBAD0_BAD0_BAD0_BAD0;
    end
    if (rstN) begin
      if (c == C_ACT) begin sinceAct = 0; rowSeen = sdAddr; end
      else sinceAct++;
      if (c == C_RD) begin
        colSeen = sdAddr[7:0];
        check(sinceAct == curRcd + 1, "R4", "model act-to-read spacing", sinceAct, curRcd + 1);
        dqCnt = 4;
        guard = 4 + curTpc;
      end else if (guard > 0) begin
        check(c == C_NOP, "R8", "model quiet-window command", c, C_NOP);
        guard--;
      end
    end
  end

  // one burst; optionally keeps reqValid high with the next request's inputs
  task automatic runBurst(input logic [22:0] addr, input int rcd, input int tpc,
                          input bit hold, input logic [22:0] nAddr,
                          input int nRcd, input int nTpc);
    int n;
    logic [255:0] expData;
    if (!reqValid) begin
      @(negedge clk);
      reqAddr = addr; cfgRcd = 2'(rcd); cfgTpc = 3'(tpc); reqValid = 1'b1;
    end
    #1;
    check(reqAck == 1'b1, "R2", "ack while idle", reqAck, 1);
    curRcd = rcd; curTpc = tpc;
    for (int i = 0; i < 4; i++) expData[64*i +: 64] = beatVal(addr[22:3], i);
    n = rcd + 6 + tpc;
    for (int idx = 0; idx <= n; idx++) begin
      logic [3:0]  expCmd;
      logic [11:0] expAddr;
      @(negedge clk);
      if (idx == 0) begin
        reqValid = hold;
        // R9: inputs change after acceptance
        reqAddr = hold ? nAddr : ~addr;
        cfgRcd  = hold ? 2'(nRcd) : ~2'(rcd);
        cfgTpc  = hold ? 3'(nTpc) : ~3'(tpc);
      end
      #1;
      if (idx == 0) begin expCmd = C_ACT; expAddr = addr[22:11]; end
      else if (idx == rcd + 1) begin
        expCmd = C_RD; expAddr = {addr[22], 1'b1, 2'b00, addr[10:3]};
      end else begin expCmd = C_NOP; expAddr = '0; end
      check({sdCsN, sdRasN, sdCasN, sdWeN} == expCmd, "R3/R4/R8/R9", "command pins",
            {sdCsN, sdRasN, sdCasN, sdWeN}, expCmd);
      check(sdAddr == expAddr, (idx == 0) ? "R5" : (idx == rcd + 1) ? "R6" : "R3",
            "address pins", sdAddr, expAddr);
      check(reqAck == (idx == n && hold), "R2", "ack during/after burst", reqAck, (idx == n && hold));
      check(rdValid == (idx == rcd + 6), "R7", "valid strobe", rdValid, (idx == rcd + 6));
      if (idx >= rcd + 6)
        check(rdData == expData, "R7", "returned beats", rdData, expData);
    end
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; cfgRcd = '0; cfgTpc = '0;
    repeat (3) @(negedge clk);
    #1;
    check({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP, "R1", "reset command", {sdCsN, sdRasN, sdCasN, sdWeN}, C_NOP);
    check(sdAddr == 0, "R1", "reset address", sdAddr, 0);
    check(reqAck == 0 && rdValid == 0, "R1", "reset handshake", {reqAck, rdValid}, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    check({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP && sdAddr == 0 && !rdValid, "R1",
          "first cycle after reset", {sdCsN, sdRasN, sdCasN, sdWeN, sdAddr}, {C_NOP, 12'h0});

    runBurst(23'h000000, 0, 0, 0, '0, 0, 0);
    runBurst(23'h7FFFFF, 3, 7, 0, '0, 0, 0);
    runBurst(23'h2A5A5F, 1, 2, 0, '0, 0, 0);
    runBurst(23'h55A5A0, 2, 1, 0, '0, 0, 0);
    // back-to-back chains, next request waiting during the burst
    runBurst(23'h400808, 1, 3, 1, 23'h13579B, 3, 0);
    runBurst(23'h13579B, 3, 0, 1, 23'h7F0018, 0, 5);
    runBurst(23'h7F0018, 0, 5, 1, 23'h0007F8, 2, 0);
    runBurst(23'h0007F8, 2, 0, 0, '0, 0, 0);
    repeat (3) @(negedge clk);
    #1;
    check(reqAck == 0 && !rdValid, "R2", "idle without request", {reqAck, rdValid}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule